// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block collects events from fifteen interrupt sources, holds each as a pending flag, and decides which one the processor core should service next. Each source has its own enable and a two-bit priority level made of one bit in a priority-high bank and one bit in a priority-low bank. A global enable gates every source. The core reads and writes enables, priorities and flags through a small byte-wide register port. Software can raise a pending interrupt or cancel one by writing its flag. The one exception is the ADC flag, which software can only clear.

The block tracks which levels are currently in service, one bit per level. A pending source is offered to the core only when its level is strictly above every level in service. This gives nested preemption: a higher level interrupts a lower one, and equal or lower levels wait. When the core returns from an interrupt, the highest level in service is released and the preempted service carries on.

The request/acknowledge pair works as a valid/ready handshake. `int_req` is the valid signal and `int_vec` is its payload. `int_ack` is the ready strobe, and it takes effect only in a cycle where `int_req` is high. An acknowledge while `int_req` is low is ignored. This is not a held stream. Because the request is recomputed every cycle from the flags, a request may change its vector, or drop, before it is acknowledged. The core is expected to act on the vector present in the cycle it acknowledges.

Top module: `irqn_top`

## Requirements
- R1: After reset all enables, priority bits, flags and in-service levels are 0, every register reads 0, and `int_req` is low.
- R2: A high bit on `evt` sets the matching flag at the next clock edge. Source s (0..13) uses `evt[s]`. `evt[14]` is the 8-bit overflow flag and `evt[15]` is the 16-bit overflow flag. Address 6 reads `{ovf8, flags of sources 6..0}` and address 7 reads `{ovf16, flags of sources 13..7}`.
- R3: A write to address 6 or 7 sets or clears each flag in it to the written bit, with the same effect as a hardware event. If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R4: The ADC flag (source 6, address 6 bit 6) can be cleared by a write but is never set by one.
- R5: Source 14 is pending whenever the 8-bit overflow flag or the 16-bit overflow flag is set.
- R6: Acknowledging sources 0 to 3 clears their flag. Flags of sources 4 to 14 survive an acknowledge, so such a source requests again after its service ends unless software clears the flag.
- R7: A source can request only if its enable bit and the global enable are both 1. The global enable is address 0 bit 7. Address 0 bits 6..0 enable sources 6..0, and address 1 bits 7..0 enable sources 14..7.
- R8: The level of source s is {priority-high bit, priority-low bit}, from 0 (lowest) to 3 (highest). The priority-low bits are at addresses 2 and 3 and the priority-high bits at addresses 4 and 5, with the same bit layout as the enables (address 2/4 bit 7 reads 0). The highest pending level wins, a tie goes to the lowest source index, and `int_vec` carries the winner's index.
- R9: `int_req` is high only when the winner's level is above every level in service. A winner at an equal or lower level waits.
- R10: An acknowledge marks the winner's level as in service. A later source at a higher level still preempts.
- R11: Each `int_reti` pulse releases the highest in-service level. Pending sources that were held back are then offered again.
- R12: Enable and priority registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt | input | 16 | Hardware event pulses, one per flag |
| int_ack | input | 1 | Core acknowledge (ready) |
| int_reti | input | 1 | Core return-from-interrupt strobe |
| int_req | output | 1 | Interrupt request (valid) |
| int_vec | output | 4 | Index of the source being requested |

## Verification
Flags, enables and priorities change at the clock edge that samples the event or the write. Because the request and vector are combinational from those registers, they are due in the same cycle as the register change, one edge after the stimulus. An acknowledge or return strobe changes the in-service set at the edge that samples it, and the request reflects the new set right after that edge. The bench drives every input on a falling edge, holds it across exactly one rising edge, and samples outputs and read data at the following falling edge. Each result is therefore read one edge after its cause, and no check depends on the order of processes at an edge.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  localparam int NSRC       = 15;
  localparam int NFLAG      = NSRC + 1;
  localparam int NLVL       = 4;
  localparam int LVLW       = $clog2(NLVL);
  localparam int VECW       = $clog2(NSRC);
  localparam int DW         = 8;
  localparam int AW         = 3;
  localparam int LO_SRC     = DW - 1;       // sources held in the low byte
  localparam int ADC_SRC    = 6;
  localparam int OVF8_FLAG  = NSRC - 1;
  localparam int OVF16_FLAG = NSRC;
  localparam logic [NSRC-1:0] ACK_CLR_MASK = NSRC'(15'h000F);

  typedef enum logic [AW-1:0] {
    RA_EN_LO = 3'd0,
    RA_EN_HI = 3'd1,
    RA_PL_LO = 3'd2,
    RA_PL_HI = 3'd3,
    RA_PH_LO = 3'd4,
    RA_PH_HI = 3'd5,
    RA_FL_LO = 3'd6,
    RA_FL_HI = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/irqn_cfg.sv
module irqn_cfg
  import irqn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic            gen,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] pl,
  output logic [NSRC-1:0] ph
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen <= 1'b0;
      en  <= '0;
      pl  <= '0;
      ph  <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr))
        RA_EN_LO: begin
          gen               <= wdata[DW-1];
          en[LO_SRC-1:0]    <= wdata[LO_SRC-1:0];
        end
        RA_EN_HI: en[NSRC-1:LO_SRC] <= wdata;
        RA_PL_LO: pl[LO_SRC-1:0]    <= wdata[LO_SRC-1:0];
        RA_PL_HI: pl[NSRC-1:LO_SRC] <= wdata;
        RA_PH_LO: ph[LO_SRC-1:0]    <= wdata[LO_SRC-1:0];
        RA_PH_HI: ph[NSRC-1:LO_SRC] <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqn_flags.sv
module irqn_flags
  import irqn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic [NFLAG-1:0] sw_mask,
  input  logic [NFLAG-1:0] sw_val,
  input  logic [NFLAG-1:0] ack_clr,
  output logic [NFLAG-1:0] flags
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic bit_q;
    logic sw_next;
    if (g == ADC_SRC) begin : g_clear_only
      assign sw_next = sw_val[g] & bit_q;   // software may only clear
    end else begin : g_set_clear
      assign sw_next = sw_val[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (evt[g])     bit_q <= 1'b1;   // hardware event always wins
      else if (ack_clr[g]) bit_q <= 1'b0;
      else if (sw_mask[g]) bit_q <= sw_next;
    end
    assign flags[g] = bit_q;
  end
endmodule

// File: rtl/irqn_arb.sv
module irqn_arb
  import irqn_pkg::*;
(
  input  logic [NSRC-1:0] active,
  input  logic [NSRC-1:0] pl,
  input  logic [NSRC-1:0] ph,
  output logic            any,
  output logic [VECW-1:0] win_idx,
  output logic [LVLW-1:0] win_lvl
);
  logic [NLVL-1:0][NSRC-1:0] hit;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign hit[l][s] = active[s] && ({ph[s], pl[s]} == LVLW'(l));
    end
  end

  always_comb begin
    any     = |active;
    win_lvl = '0;
    win_idx = '0;
    for (int l = 0; l < NLVL; l++)
      if (|hit[l]) win_lvl = LVLW'(l);
    for (int s = NSRC - 1; s >= 0; s--)
      if (hit[win_lvl][s]) win_idx = VECW'(s);
  end
endmodule

// File: rtl/irqn_insvc.sv
module irqn_insvc
  import irqn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [LVLW-1:0] push_lvl,
  input  logic            pop,
  output logic [NLVL-1:0] isr,
  output logic            busy,
  output logic [LVLW-1:0] top_lvl
);
  logic [NLVL-1:0] pop_mask;
  logic [NLVL-1:0] push_mask;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (isr[l]) top_lvl = LVLW'(l);
  end

  assign busy      = |isr;
  assign pop_mask  = (pop && busy) ? (NLVL'(1) << top_lvl) : '0;
  assign push_mask = push ? (NLVL'(1) << push_lvl) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~pop_mask) | push_mask;
  end
endmodule

// File: rtl/irqn_top.sv
module irqn_top
  import irqn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NFLAG-1:0] evt,
  input  logic             int_ack,
  input  logic             int_reti,
  output logic             int_req,
  output logic [VECW-1:0]  int_vec
);
  logic            cfg_gen;
  logic [NSRC-1:0] cfg_en, cfg_pl, cfg_ph;
  logic [NFLAG-1:0] flag_q, sw_mask, sw_val, ack_clr;
  logic [NSRC-1:0] pend, active;
  logic            arb_any, ack_take, isr_busy;
  logic [VECW-1:0] win_idx;
  logic [LVLW-1:0] win_lvl, isr_top;
  logic [NLVL-1:0] isr_q;

  irqn_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .gen(cfg_gen), .en(cfg_en), .pl(cfg_pl), .ph(cfg_ph)
  );

  // software flag write: map the two flag bytes onto the flag vector
  always_comb begin
    sw_mask = '0;
    sw_val  = '0;
    if (reg_wr && reg_addr == RA_FL_LO) begin
      sw_mask[LO_SRC-1:0] = '1;
      sw_mask[OVF8_FLAG]  = 1'b1;
      sw_val[LO_SRC-1:0]  = reg_wdata[LO_SRC-1:0];
      sw_val[OVF8_FLAG]   = reg_wdata[DW-1];
    end
    if (reg_wr && reg_addr == RA_FL_HI) begin
      sw_mask[OVF8_FLAG-1:LO_SRC] = '1;
      sw_mask[OVF16_FLAG]         = 1'b1;
      sw_val[OVF8_FLAG-1:LO_SRC]  = reg_wdata[DW-2:0];
      sw_val[OVF16_FLAG]          = reg_wdata[DW-1];
    end
  end

  assign ack_take = int_ack && int_req;
  assign ack_clr  = (ack_take && ACK_CLR_MASK[win_idx]) ? (NFLAG'(1) << win_idx) : '0;

  irqn_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sw_mask(sw_mask), .sw_val(sw_val),
    .ack_clr(ack_clr), .flags(flag_q)
  );

  assign pend   = {flag_q[OVF16_FLAG] | flag_q[OVF8_FLAG], flag_q[OVF8_FLAG-1:0]};
  assign active = pend & cfg_en & {NSRC{cfg_gen}};

  irqn_arb u_arb (
    .active(active), .pl(cfg_pl), .ph(cfg_ph),
    .any(arb_any), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irqn_insvc u_insvc (
    .clk(clk), .rst_n(rst_n), .push(ack_take), .push_lvl(win_lvl), .pop(int_reti),
    .isr(isr_q), .busy(isr_busy), .top_lvl(isr_top)
  );

  assign int_req = arb_any && (!isr_busy || win_lvl > isr_top);
  assign int_vec = win_idx;

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_EN_LO: reg_rdata = {cfg_gen, cfg_en[LO_SRC-1:0]};
      RA_EN_HI: reg_rdata = cfg_en[NSRC-1:LO_SRC];
      RA_PL_LO: reg_rdata = {1'b0, cfg_pl[LO_SRC-1:0]};
      RA_PL_HI: reg_rdata = cfg_pl[NSRC-1:LO_SRC];
      RA_PH_LO: reg_rdata = {1'b0, cfg_ph[LO_SRC-1:0]};
      RA_PH_HI: reg_rdata = cfg_ph[NSRC-1:LO_SRC];
      RA_FL_LO: reg_rdata = {flag_q[OVF8_FLAG], flag_q[LO_SRC-1:0]};
      RA_FL_HI: reg_rdata = {flag_q[OVF16_FLAG], flag_q[OVF8_FLAG-1:LO_SRC]};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqn_chk.sv
module irqn_chk
  import irqn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] evt,
  input logic [NFLAG-1:0] flag_q,
  input logic             cfg_gen,
  input logic             int_req,
  input logic             int_ack,
  input logic             int_reti,
  input logic [LVLW-1:0]  win_lvl,
  input logic [NLVL-1:0]  isr_q
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt)));

  assert_adc_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[ADC_SRC] && !evt[ADC_SRC]) |=> !flag_q[ADC_SRC]);

  assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> cfg_gen);

  assert_above_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((isr_q >> win_lvl) == '0));

  assert_ack_marks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req && !int_reti) |=> isr_q[$past(win_lvl)]);

  assert_reti_pops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_reti && !int_ack && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

bind irqn_top irqn_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .flag_q(flag_q), .cfg_gen(cfg_gen),
  .int_req(int_req), .int_ack(int_ack), .int_reti(int_reti),
  .win_lvl(win_lvl), .isr_q(isr_q)
);

// File: tb/test_irqn_top.sv
module test_irqn_top;
  logic        clk = 1'b0;
  logic        rst_n, reg_wr, int_ack, int_reti, int_req;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [15:0] evt;
  logic [3:0]  int_vec;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irqn_top i_irqn_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .int_ack(int_ack), .int_reti(int_reti), .int_req(int_req), .int_vec(int_vec)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [2:0] a, input int exp);
    reg_addr = a; #1;
    check(rq, int'(reg_rdata), exp);
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic strobe_ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  task automatic strobe_reti();
    @(negedge clk); int_reti = 1'b1;
    @(negedge clk); int_reti = 1'b0;
  endtask

  task automatic req_chk(input string rq, input bit er, input int ev);
    check(rq, int'(int_req), int'(er));
    if (er) check(rq, int'(int_vec), ev);
  endtask

  task automatic clr_flags();
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [14:0] pl, ph;
    int exp_w;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt = '0; int_ack = 1'b0; int_reti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 0);
    req_chk("R1", 1'b0, 0);

    // R12: readback
    wr(3'd1, 8'hA5); rd_chk("R12", 3'd1, 'hA5);
    wr(3'd2, 8'hFF); rd_chk("R12", 3'd2, 'h7F);
    wr(3'd5, 8'h3C); rd_chk("R12", 3'd5, 'h3C);
    wr(3'd2, 8'h00); wr(3'd5, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    rd_chk("R12", 3'd0, 'hFF);

    // R4: ADC flag cannot be set by software
    wr(3'd6, 8'h40); rd_chk("R4", 3'd6, 0); req_chk("R4", 1'b0, 0);
    pulse(16'h0040); rd_chk("R2", 3'd6, 'h40); req_chk("R2", 1'b1, 6);
    wr(3'd6, 8'h00); rd_chk("R4", 3'd6, 0);

    // R3: software set / clear, hardware wins on collision
    wr(3'd6, 8'h10); rd_chk("R3", 3'd6, 'h10); req_chk("R3", 1'b1, 4);
    wr(3'd6, 8'h00); rd_chk("R3", 3'd6, 0); req_chk("R3", 1'b0, 0);
    @(negedge clk); evt = 16'h0010; reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
    @(negedge clk); evt = '0; reg_wr = 1'b0;
    rd_chk("R3", 3'd6, 'h10);
    clr_flags();

    // R5: either overflow flag makes source 14 pending
    wr(3'd7, 8'h80); rd_chk("R5", 3'd7, 'h80); req_chk("R5", 1'b1, 14);
    wr(3'd6, 8'h80); wr(3'd7, 8'h00); req_chk("R5", 1'b1, 14);
    rd_chk("R5", 3'd6, 'h80);
    pulse(16'h8000); rd_chk("R2", 3'd7, 'h80);
    clr_flags(); req_chk("R5", 1'b0, 0);

    // R7: global and per-source enables
    wr(3'd0, 8'h7F); pulse(16'h0002); req_chk("R7", 1'b0, 0);
    wr(3'd0, 8'hFF); req_chk("R7", 1'b1, 1);
    clr_flags();
    for (int s = 0; s < 15; s++) begin
      if (s < 7) wr(3'd0, 8'hFF & ~(8'd1 << s));
      else       wr(3'd1, 8'hFF & ~(8'd1 << (s - 7)));
      pulse(16'd1 << s);
      req_chk("R7", 1'b0, 0);
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
      req_chk("R7", 1'b1, s);
      clr_flags();
    end

    // R8: pairwise arbitration sweep over all sources and levels
    for (int a = 0; a < 15; a++)
      for (int b = 0; b < 15; b++) begin
        if (a == b) continue;
        for (int la = 0; la < 4; la++)
          for (int lb = 0; lb < 4; lb++) begin
            pl = '0; ph = '0;
            pl[a] = la[0]; ph[a] = la[1];
            pl[b] = lb[0]; ph[b] = lb[1];
            wr(3'd2, {1'b0, pl[6:0]}); wr(3'd3, pl[14:7]);
            wr(3'd4, {1'b0, ph[6:0]}); wr(3'd5, ph[14:7]);
            pulse((16'd1 << a) | (16'd1 << b));
            if (la > lb)      exp_w = a;
            else if (lb > la) exp_w = b;
            else              exp_w = (a < b) ? a : b;
            req_chk("R8", 1'b1, exp_w);
            clr_flags();
          end
      end

    // Nesting: src0 level0, src7/src9 level1, src8 level3
    wr(3'd2, 8'h00); wr(3'd4, 8'h00);
    wr(3'd3, 8'h07); wr(3'd5, 8'h02);
    pulse(16'h0001); req_chk("R8", 1'b1, 0);
    strobe_ack();    req_chk("R10", 1'b0, 0);
    rd_chk("R6", 3'd6, 0);                       // source 0 cleared by ack
    pulse(16'h0080); req_chk("R10", 1'b1, 7);    // level 1 preempts level 0
    strobe_ack();    req_chk("R9", 1'b0, 0);
    rd_chk("R6", 3'd7, 'h01);                    // source 7 survives ack
    pulse(16'h0200); req_chk("R9", 1'b0, 0);     // equal level waits
    pulse(16'h0100); req_chk("R10", 1'b1, 8);    // level 3 preempts
    strobe_ack();    req_chk("R10", 1'b0, 0);
    strobe_reti();   req_chk("R6", 1'b1, 8);     // flag 8 still set, recurs
    wr(3'd7, 8'h05); req_chk("R3", 1'b0, 0);     // cancel source 8
    strobe_reti();   req_chk("R11", 1'b1, 7);    // level 1 released
    strobe_reti();   req_chk("R11", 1'b1, 7);
    strobe_reti();   req_chk("R11", 1'b1, 7);    // empty stack: no change
    clr_flags();     req_chk("R11", 1'b0, 0);
    strobe_ack();    req_chk("R10", 1'b0, 0);    // ack with no request ignored
    pulse(16'h0001); req_chk("R10", 1'b1, 0);

    summary();
  end
endmodule